// File: doc/BRIEF.md
# SPI FIFO and interrupt register bank

This block is the host-facing register bank of a byte-wide SPI master. It holds a transmit queue and a receive queue of equal, parameterised depth. The host reaches them and a small set of control words through a plain 32-bit register bus with address, write strobe, read strobe, write data and read data. The serial shift engine sits on the other side. It takes transmit bytes through a pop port, delivers received bytes through a push port, and signals the end of a transfer with a one-cycle strobe.

The host queues bytes by writing the transmit data address. It collects received bytes by reading the receive data address, and each such read removes one byte. It can see how full both queues are in a single status word and can flush either queue with a self-clearing control bit. Two events are latched in a pending word: the end of a transfer and a receive byte that was lost because the queue was full. A one written to a pending bit clears it. An enable word masks the pending bits onto a single interrupt line.

Read data is combinational: it is valid in the same cycle as the read strobe. Side effects of the access take place at the following clock edge.

Top module: `spim_fifo_regs`

## Requirements
- R1: After reset both queues are empty, the enable and pending words read zero, `irq` is low and `eng_tx_empty` is high.
- R2: A bus write to 0x200 queues `bus_wdata[7:0]` for transmission. `eng_tx_byte` shows the oldest queued byte, and `eng_tx_pop` removes it, so bytes leave in write order. The transmit fill count reads at 0x1C, in the field whose lowest bit is bit 16.
- R3: `eng_rx_push` stores `eng_rx_byte`. A bus read of 0x300 returns the oldest stored byte in bits 7:0 and removes it. The receive fill count reads at 0x1C, in the field whose lowest bit is bit 0.
- R4: A receive push while the receive queue is full is dropped and sets pending bit 8 at 0x14. If the host removes a byte in the same cycle, the push is accepted and no loss is flagged.
- R5: An `eng_done` strobe sets pending bit 12 at 0x14.
- R6: Writing a one to a pending bit at 0x14 clears it, and writing zero leaves it unchanged. If an event sets a bit in the same cycle as a clear, the set wins.
- R7: The enable word at 0x10 holds bits 12 and 8 and reads zero elsewhere. `irq` is high whenever some pending bit is set together with its enable bit.
- R8: Writing bit 15 at 0x18 empties the receive queue, and writing bit 31 empties the transmit queue. The bit reads back as one for the single cycle after the write and as zero from then on, and the queue is empty by then.
- R9: Reading 0x300 with the receive queue empty returns zero and changes no count. `eng_tx_pop` on an empty transmit queue changes nothing, and `eng_tx_byte` reads zero.
- R10: A write to 0x200 while the transmit queue is full is dropped and leaves the count at the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while the read strobe is high |
| eng_tx_pop | input | 1 | Engine removes the oldest transmit byte |
| eng_tx_byte | output | 8 | Oldest transmit byte (zero when empty) |
| eng_tx_empty | output | 1 | Transmit queue is empty |
| eng_rx_push | input | 1 | Engine stores a received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_done | input | 1 | End-of-transfer strobe |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is an end-of-transfer strobe and a host write-one-to-clear of the same pending bit. The second is an engine push into a full receive queue and a host read that drains it. The bench drives each pair in a single cycle. It then judges the first by reading the pending word, which must still show bit 12. It judges the second by the returned byte, an unchanged full count and a clear loss bit.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFF_IEN  = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_ISTS = 12'h014;
    localparam logic [ADDR_W-1:0] OFF_FCTL = 12'h018;
    localparam logic [ADDR_W-1:0] OFF_FSTS = 12'h01C;
    localparam logic [ADDR_W-1:0] OFF_TXD  = 12'h200;
    localparam logic [ADDR_W-1:0] OFF_RXD  = 12'h300;

    localparam int BIT_DONE  = 12;
    localparam int BIT_LOSS  = 8;
    localparam int BIT_RXCLR = 15;
    localparam int BIT_TXCLR = 31;
    localparam int TXCNT_LSB = 16;

    typedef struct packed {
        logic en_done;
        logic en_loss;
        logic pend_done;
        logic pend_loss;
    } irq_state_t;

    typedef struct packed {
        logic rx_clr;
        logic tx_clr;
    } clr_state_t;

endpackage

// File: rtl/spim_byte_fifo.sv
module spim_byte_fifo #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty,
    output logic              drop
);

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && (st_q.cnt != '0) && !flush;
        do_push = push && !flush && ((st_q.cnt != CNT_W'(DEPTH)) || do_pop);
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_pop)  st_d.rd = st_q.rd + PTR_W'(1);
            if (do_push) st_d.wr = st_q.wr + PTR_W'(1);
            st_d.cnt = st_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wr] <= din;
    end

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CNT_W'(DEPTH));
    assign count = st_q.cnt;
    assign dout  = empty ? '0 : mem[st_q.rd];
    assign drop  = push && !flush && !do_push;

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));

    p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (count == '0));

    p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/spim_irq_ctl.sv
module spim_irq_ctl
    import spim_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_we,
    input  logic pend_we,
    input  logic wd_done,
    input  logic wd_loss,
    input  logic ev_done,
    input  logic ev_loss,
    output logic en_done,
    output logic en_loss,
    output logic pend_done,
    output logic pend_loss,
    output logic irq
);

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_we) begin
            st_d.en_done = wd_done;
            st_d.en_loss = wd_loss;
        end
        if (pend_we && wd_done) st_d.pend_done = 1'b0;
        if (pend_we && wd_loss) st_d.pend_loss = 1'b0;
        if (ev_done) st_d.pend_done = 1'b1;
        if (ev_loss) st_d.pend_loss = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_done   = st_q.en_done;
    assign en_loss   = st_q.en_loss;
    assign pend_done = st_q.pend_done;
    assign pend_loss = st_q.pend_loss;
    assign irq       = (st_q.pend_done && st_q.en_done) || (st_q.pend_loss && st_q.en_loss);

    p_done_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |=> pend_done);

    p_loss_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_loss |=> pend_loss);

    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_we && wd_done && !ev_done) |=> !pend_done);

    p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_done && en_done && !en_we) |=> irq);

endmodule

// File: rtl/spim_fifo_regs.sv
module spim_fifo_regs
    import spim_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [11:0]       bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              eng_tx_pop,
    output logic [DATA_W-1:0] eng_tx_byte,
    output logic              eng_tx_empty,
    input  logic              eng_rx_push,
    input  logic [DATA_W-1:0] eng_rx_byte,
    input  logic              eng_done,
    output logic              irq
);

    clr_state_t clr_d, clr_q;

    logic             tx_push, host_pop;
    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    logic             tx_full, rx_full, rx_empty, tx_drop, rx_drop;
    logic [DATA_W-1:0] rx_head;
    logic             en_done, en_loss, pend_done, pend_loss;
    logic             unused_wdata;

    assign tx_push  = bus_wr && (bus_addr == OFF_TXD);
    assign host_pop = bus_rd && (bus_addr == OFF_RXD);
    assign unused_wdata = ^bus_wdata;

    always_comb begin
        clr_d        = '0;
        if (bus_wr && (bus_addr == OFF_FCTL)) begin
            clr_d.rx_clr = bus_wdata[BIT_RXCLR];
            clr_d.tx_clr = bus_wdata[BIT_TXCLR];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clr_q <= '0;
        else        clr_q <= clr_d;
    end

    spim_byte_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (clr_q.tx_clr),
        .push  (tx_push),
        .din   (bus_wdata[DATA_W-1:0]),
        .pop   (eng_tx_pop),
        .dout  (eng_tx_byte),
        .count (tx_cnt),
        .full  (tx_full),
        .empty (eng_tx_empty),
        .drop  (tx_drop)
    );

    spim_byte_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (clr_q.rx_clr),
        .push  (eng_rx_push),
        .din   (eng_rx_byte),
        .pop   (host_pop),
        .dout  (rx_head),
        .count (rx_cnt),
        .full  (rx_full),
        .empty (rx_empty),
        .drop  (rx_drop)
    );

    spim_irq_ctl u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_we     (bus_wr && (bus_addr == OFF_IEN)),
        .pend_we   (bus_wr && (bus_addr == OFF_ISTS)),
        .wd_done   (bus_wdata[BIT_DONE]),
        .wd_loss   (bus_wdata[BIT_LOSS]),
        .ev_done   (eng_done),
        .ev_loss   (rx_drop),
        .en_done   (en_done),
        .en_loss   (en_loss),
        .pend_done (pend_done),
        .pend_loss (pend_loss),
        .irq       (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFF_IEN: begin
                    bus_rdata[BIT_DONE] = en_done;
                    bus_rdata[BIT_LOSS] = en_loss;
                end
                OFF_ISTS: begin
                    bus_rdata[BIT_DONE] = pend_done;
                    bus_rdata[BIT_LOSS] = pend_loss;
                end
                OFF_FCTL: begin
                    bus_rdata[BIT_RXCLR] = clr_q.rx_clr;
                    bus_rdata[BIT_TXCLR] = clr_q.tx_clr;
                end
                OFF_FSTS: begin
                    bus_rdata[CNT_W-1:0]              = rx_cnt;
                    bus_rdata[TXCNT_LSB +: CNT_W]     = tx_cnt;
                end
                OFF_RXD:  bus_rdata[DATA_W-1:0] = rx_head;
                default:  bus_rdata = '0;
            endcase
        end
    end

    p_rx_loss_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_push && rx_full && !host_pop && !clr_q.rx_clr) |=> pend_loss);

    p_clr_selfclear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_q.rx_clr |=> !clr_q.rx_clr);

    p_tx_full_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_drop && !eng_tx_pop) |=> tx_full);

    p_rx_empty_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_pop && rx_empty && !eng_rx_push) |=> rx_empty);

endmodule

// File: tb/spim_fifo_regs_bench.sv
module spim_fifo_regs_bench;

    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_tx_pop = 1'b0;
    logic [7:0]  eng_tx_byte;
    logic        eng_tx_empty;
    logic        eng_rx_push = 1'b0;
    logic [7:0]  eng_rx_byte = '0;
    logic        eng_done = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    spim_fifo_regs #(.DEPTH(DEPTH), .DATA_W(8)) u_spim_fifo_regs (
        .clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_wdata, .bus_rdata,
        .eng_tx_pop, .eng_tx_byte, .eng_tx_empty, .eng_rx_push, .eng_rx_byte,
        .eng_done, .irq
    );

    // op: 0 write, 1 read+check, 2 rx push, 3 tx pop+check byte, 4 done strobe, 5 check irq
    typedef struct packed {
        logic [2:0]  op;
        logic [3:0]  req;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 4'd2,  12'h200, 32'h0000_00A5, 32'h0},          // R2 queue
        '{3'd0, 4'd2,  12'h200, 32'h0000_003C, 32'h0},
        '{3'd1, 4'd2,  12'h01C, 32'h0,         32'h0002_0000},  // R2 count
        '{3'd3, 4'd2,  12'h000, 32'h0,         32'h0000_00A5},  // R2 order
        '{3'd3, 4'd2,  12'h000, 32'h0,         32'h0000_003C},
        '{3'd1, 4'd2,  12'h01C, 32'h0,         32'h0},
        '{3'd2, 4'd3,  12'h000, 32'h0000_0011, 32'h0},          // R3 store
        '{3'd2, 4'd3,  12'h000, 32'h0000_0022, 32'h0},
        '{3'd1, 4'd3,  12'h01C, 32'h0,         32'h0000_0002},  // R3 count
        '{3'd1, 4'd3,  12'h300, 32'h0,         32'h0000_0011},  // R3 oldest
        '{3'd1, 4'd3,  12'h300, 32'h0,         32'h0000_0022},
        '{3'd1, 4'd9,  12'h300, 32'h0,         32'h0},          // R9 empty read
        '{3'd1, 4'd9,  12'h01C, 32'h0,         32'h0},
        '{3'd0, 4'd7,  12'h010, 32'hFFFF_FFFF, 32'h0},          // R7 enable
        '{3'd1, 4'd7,  12'h010, 32'h0,         32'h0000_1100},
        '{3'd4, 4'd5,  12'h000, 32'h0,         32'h0},          // R5 event
        '{3'd1, 4'd5,  12'h014, 32'h0,         32'h0000_1000},
        '{3'd5, 4'd7,  12'h000, 32'h0,         32'h1},
        '{3'd0, 4'd6,  12'h014, 32'h0000_1000, 32'h0},          // R6 clear
        '{3'd1, 4'd6,  12'h014, 32'h0,         32'h0},
        '{3'd5, 4'd7,  12'h000, 32'h0,         32'h0},
        '{3'd0, 4'd7,  12'h010, 32'h0,         32'h0},          // R7 masked
        '{3'd4, 4'd5,  12'h000, 32'h0,         32'h0},
        '{3'd5, 4'd7,  12'h000, 32'h0,         32'h0},
        '{3'd1, 4'd5,  12'h014, 32'h0,         32'h0000_1000},
        '{3'd0, 4'd6,  12'h014, 32'hFFFF_FFFF, 32'h0},
        '{3'd1, 4'd6,  12'h014, 32'h0,         32'h0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] b);
        @(negedge clk);
        eng_rx_byte = b; eng_rx_push = 1'b1;
        @(posedge clk); #1;
        eng_rx_push = 1'b0;
    endtask

    task automatic tx_pop(output logic [7:0] b);
        @(negedge clk);
        eng_tx_pop = 1'b1;
        #1 b = eng_tx_byte;
        @(posedge clk); #1;
        eng_tx_pop = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        eng_done = 1'b1;
        @(posedge clk); #1;
        eng_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [7:0]  b;

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        bus_read(12'h01C, r); check("R1 counts", r, 32'h0);
        bus_read(12'h014, r); check("R1 pending", r, 32'h0);
        bus_read(12'h010, r); check("R1 enable", r, 32'h0);
        @(negedge clk); #1;
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 tx_empty", {31'h0, eng_tx_empty}, 32'h1);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
            case (VEC[i].op)
                3'd0: bus_write(VEC[i].addr, VEC[i].data);
                3'd1: begin bus_read(VEC[i].addr, r); check(tag, r, VEC[i].exp); end
                3'd2: rx_push(VEC[i].data[7:0]);
                3'd3: begin tx_pop(b); check(tag, {24'h0, b}, VEC[i].exp); end
                3'd4: done_pulse();
                default: begin @(negedge clk); #1 check(tag, {31'h0, irq}, VEC[i].exp); end
            endcase
        end

        // R4 fill receive queue, then overflow
        for (int i = 0; i < DEPTH; i++) rx_push(8'(i));
        bus_read(12'h01C, r); check("R3 full count", r, 32'h0000_0040);
        rx_push(8'hEE);
        bus_read(12'h014, r); check("R4 loss flag", r, 32'h0000_0100);
        bus_read(12'h01C, r); check("R4 count held", r, 32'h0000_0040);
        bus_read(12'h300, r); check("R4 oldest kept", r, 32'h0000_0000);

        // R8 receive flush self-clearing
        bus_write(12'h018, 32'h0000_8000);
        bus_read(12'h018, r); check("R8 bit one cycle", r, 32'h0000_8000);
        bus_read(12'h018, r); check("R8 bit cleared", r, 32'h0);
        bus_read(12'h01C, r); check("R8 rx emptied", r, 32'h0);

        // R4 push and host pop in the same cycle on a full queue
        for (int i = 0; i < DEPTH; i++) rx_push(8'(i + 1));
        bus_write(12'h014, 32'h0000_0100);
        @(negedge clk);
        eng_rx_byte = 8'h77; eng_rx_push = 1'b1;
        bus_addr = 12'h300; bus_rd = 1'b1;
        #1 r = bus_rdata;
        @(posedge clk); #1;
        eng_rx_push = 1'b0; bus_rd = 1'b0;
        check("R4 same-cycle data", r, 32'h0000_0001);
        bus_read(12'h01C, r); check("R4 same-cycle count", r, 32'h0000_0040);
        bus_read(12'h014, r); check("R4 no loss", r, 32'h0);
        bus_read(12'h300, r); check("R3 next byte", r, 32'h0000_0002);

        // R6 set beats clear in the same cycle
        @(negedge clk);
        bus_addr = 12'h014; bus_wdata = 32'h0000_1000; bus_wr = 1'b1; eng_done = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0; eng_done = 1'b0;
        bus_read(12'h014, r); check("R6 set wins", r, 32'h0000_1000);

        // R9 pop on empty transmit queue
        tx_pop(b); check("R9 tx empty byte", {24'h0, b}, 32'h0);
        bus_read(12'h01C, r); check("R9 tx count", r[31:16], 32'h0);

        // R10 transmit queue full
        for (int i = 0; i < DEPTH; i++) bus_write(12'h200, 32'(i + 8'h40));
        bus_write(12'h200, 32'h0000_00FF);
        bus_read(12'h01C, r); check("R10 tx count held", r, 32'h0040_003F);
        tx_pop(b); check("R10 tx head", {24'h0, b}, 32'h0000_0040);

        // R8 transmit flush
        bus_write(12'h018, 32'h8000_0000);
        bus_read(12'h018, r); check("R8 tx bit one cycle", r, 32'h8000_0000);
        bus_read(12'h01C, r); check("R8 tx emptied", r[31:16], 32'h0);
        @(negedge clk); #1;
        check("R8 tx_empty", {31'h0, eng_tx_empty}, 32'h1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule